// File: doc/BRIEF.md
# MII Transmit Framer

This block turns a byte stream into an Ethernet frame on a 4-bit media-independent interface. Bytes arrive over a valid/ready handshake, with a start flag on the first byte of a packet and an end flag on the last. When a start flag is seen, the block emits the preamble and start delimiter. It then sends each payload byte as two nibbles while it folds those nibbles into a CRC-32. Right after the last payload nibble, it sends the complemented CRC as the frame check sequence, with no idle cycle in between. It then holds the enable low for the inter-packet gap before it accepts the next start flag.

The whole block runs from the transmit clock that the PHY supplies (25 MHz). The PHY samples on the rising edge. For that reason the nibble and enable go out through a register clocked on the falling edge, so they are settled half a period before each rising edge. A byte is taken from the input in the cycle its high nibble is launched, which gives one byte every two clocks. If the input runs dry in the middle of a frame, the frame is cut short and an error pulse is raised.

Top module: `mii_tx_framer`

## Requirements
- R1: During a frame, exactly one nibble is sent per clock with `mii_tx_en` high, and each payload byte is sent low nibble (bits 3:0) first, then high nibble (bits 7:4).
- R2: `mii_txd` and `mii_tx_en` change only on the falling clock edge, so they are stable across each rising edge.
- R3: A frame starts with fifteen nibbles of 0x5 followed by one nibble of 0xD (seven 0x55 bytes and one 0xD5 byte, low nibble first).
- R4: The FCS is the complement of a CRC-32 with reflected polynomial 0xEDB88320, initialised to all ones and run over the payload bits in wire order (bit 0 of each nibble first). It is sent as eight nibbles, least significant nibble first (low byte first, low nibble first), and its first nibble follows the last payload nibble in the very next clock.
- R5: Between the end of one frame and the start of the next, `mii_tx_en` stays low for at least 24 clocks.
- R6: `in_ready` is low during preamble, FCS and gap. In a frame, a byte is accepted only in the clock its high nibble is sent. From idle, the first byte is accepted 18 clocks after it is offered, and each later byte 1 clock after it is offered.
- R7: If `in_valid` is low when a byte's low nibble is due, `mii_tx_en` drops in that clock, no FCS is sent, `tx_err` pulses high for exactly one clock, and the gap follows.
- R8: In idle, a byte offered without the start flag is accepted (`in_ready` high) and discarded, and nothing is transmitted.
- R9: After reset, `mii_tx_en`, `mii_txd`, `in_ready` (with `in_valid` low) and `tx_err` are all 0.
- R10: `mii_txd` is 0 whenever `mii_tx_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock from the PHY |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte is valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Byte is the first of a packet |
| in_eof | input | 1 | Byte is the last of a packet |
| in_ready | output | 1 | Byte is taken at this rising edge |
| mii_txd | output | 4 | Transmit nibble to the PHY |
| mii_tx_en | output | 1 | Transmit enable to the PHY |
| tx_err | output | 1 | One-clock pulse on a mid-frame underrun |

## Verification
Two things can happen in the same clock: taking the final payload byte, and handing the updated CRC over to the FCS stage. The cycle that accepts a byte flagged as the last one also folds its high nibble into the CRC, and the next clock must already drive the first FCS nibble from that updated value. The bench provokes this with a one-byte frame, where the preamble, a single fold pair and the FCS come back to back. It also provokes it with longer frames, and offers a new start flag while the gap counter is still running. The scoreboard judges each case by comparing every nibble with its own CRC model, and by measuring the low run of the enable between frames.

// File: rtl/mtx_pkg.sv
`timescale 1ns/1ps
// mtx_pkg: shared types and line constants for the MII transmit framer.
// Assumes nibble-wide transmit with bytes sent low nibble first.
package mtx_pkg;

    // Framer sequencing states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_DATA,
        ST_FCS,
        ST_GAP
    } mtx_state_e;

    // Nibble sent for every preamble position except the last
    localparam logic [3:0] PRE_NIBBLE = 4'h5;
    // Final nibble of the start delimiter (its last two wire bits are 1,1)
    localparam logic [3:0] SFD_NIBBLE = 4'hD;

endpackage

// File: rtl/mtx_crc_nib.sv
`timescale 1ns/1ps
// mtx_crc_nib: reflected CRC register that folds one nibble per clock
// (bit 0 first) and can shift its contents out four bits at a time.
// Assumes the caller raises at most one of clear/fold/shift per clock.
module mtx_crc_nib #(
    parameter int          CRC_W    = 32,
    parameter logic [31:0] CRC_POLY = 32'hEDB88320
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       fold,
    input  logic       shift,
    input  logic [3:0] nib,
    output logic [3:0] fcs_nib
);
    localparam logic [CRC_W-1:0] POLY_W = CRC_POLY[CRC_W-1:0];

    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] fold_val;

    // Fold four data bits into the running remainder, wire order
    always_comb begin
        fold_val = crc_q;
        for (int b = 0; b < 4; b++) begin
            if (fold_val[0] ^ nib[b]) begin
                fold_val = (fold_val >> 1) ^ POLY_W;
            end else begin
                fold_val = fold_val >> 1;
            end
        end
    end

    // Remainder register: preset, accumulate, or drain by a nibble
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= '1;
        end else if (clear) begin
            crc_q <= '1;
        end else if (fold) begin
            crc_q <= fold_val;
        end else if (shift) begin
            crc_q <= crc_q >> 4;
        end
    end

    assign fcs_nib = ~crc_q[3:0];

endmodule

// File: rtl/mtx_gap_timer.sv
`timescale 1ns/1ps
// mtx_gap_timer: down counter that times the inter-packet gap.
// Loaded on entry to the gap; expired is high in the last gap clock.
module mtx_gap_timer #(
    parameter int GAP_CLKS = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(GAP_CLKS + 1);

    logic [CW-1:0] cnt_q;

    // Count down from GAP_CLKS-1 while the gap state is active
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CW'(GAP_CLKS - 1);
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/mtx_launch.sv
`timescale 1ns/1ps
// mtx_launch: falling-edge output register for the PHY pins, so data
// is settled half a period before the PHY samples on the rising edge.
// Assumes its inputs are settled by the falling edge of each clock.
module mtx_launch #(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NIB_W-1:0] d_nib,
    input  logic             d_en,
    output logic [NIB_W-1:0] q_nib,
    output logic             q_en
);
    // Capture the next pin values at the falling edge
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            q_nib <= '0;
            q_en  <= 1'b0;
        end else begin
            q_nib <= d_nib;
            q_en  <= d_en;
        end
    end

endmodule

// File: rtl/mii_tx_framer.sv
`timescale 1ns/1ps
// mii_tx_framer: sends framed bytes on a 4-bit MII transmit port with
// preamble, delimiter, in-line CRC-32 FCS and an enforced idle gap.
// Assumes one clock domain (the PHY transmit clock), and that an offered
// byte is held stable until it is accepted.
module mii_tx_framer #(
    parameter int          PRE_BYTES = 7,
    parameter int          IPG_BYTES = 12,
    parameter logic [31:0] CRC_POLY  = 32'hEDB88320
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_sof,
    input  logic       in_eof,
    output logic       in_ready,
    output logic [3:0] mii_txd,
    output logic       mii_tx_en,
    output logic       tx_err
);
    import mtx_pkg::*;

    localparam int CRC_W   = 32;
    localparam int PRE_NIB = 2 * PRE_BYTES + 2;
    localparam int IPG_NIB = 2 * IPG_BYTES;
    localparam int FCS_NIB = CRC_W / 4;
    localparam int CNT_MAX = (PRE_NIB > FCS_NIB) ? PRE_NIB : FCS_NIB;
    localparam int CNT_W   = $clog2(CNT_MAX);

    mtx_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             ph_q, ph_d;
    logic             err_q, err_d;

    logic             crc_clear, crc_fold, crc_shift;
    logic [3:0]       fcs_nib;
    logic             gap_load, gap_expired;

    logic             core_en;
    logic [3:0]       core_nib;
    logic             frame_busy;

    // Sequencing, nibble selection and input handshake for one clock
    always_comb begin
        st_d      = st_q;
        cnt_d     = cnt_q;
        ph_d      = ph_q;
        err_d     = 1'b0;
        crc_clear = 1'b0;
        crc_fold  = 1'b0;
        crc_shift = 1'b0;
        gap_load  = 1'b0;
        core_en   = 1'b0;
        core_nib  = '0;
        in_ready  = 1'b0;
        case (st_q)
            ST_IDLE: begin
                in_ready = in_valid && !in_sof;
                if (in_valid && in_sof) begin
                    st_d      = ST_PRE;
                    cnt_d     = '0;
                    crc_clear = 1'b1;
                end
            end
            ST_PRE: begin
                core_en = 1'b1;
                if (cnt_q == CNT_W'(PRE_NIB - 1)) begin
                    core_nib = SFD_NIBBLE;
                    st_d     = ST_DATA;
                    ph_d     = 1'b0;
                end else begin
                    core_nib = PRE_NIBBLE;
                    cnt_d    = cnt_q + 1'b1;
                end
            end
            ST_DATA: begin
                if (ph_q) begin
                    core_en  = 1'b1;
                    core_nib = in_data[7:4];
                    in_ready = 1'b1;
                    crc_fold = 1'b1;
                    ph_d     = 1'b0;
                    if (in_eof) begin
                        st_d  = ST_FCS;
                        cnt_d = '0;
                    end
                end else if (in_valid) begin
                    core_en  = 1'b1;
                    core_nib = in_data[3:0];
                    crc_fold = 1'b1;
                    ph_d     = 1'b1;
                end else begin
                    err_d    = 1'b1;
                    st_d     = ST_GAP;
                    gap_load = 1'b1;
                end
            end
            ST_FCS: begin
                core_en   = 1'b1;
                core_nib  = fcs_nib;
                crc_shift = 1'b1;
                if (cnt_q == CNT_W'(FCS_NIB - 1)) begin
                    st_d     = ST_GAP;
                    gap_load = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_GAP: begin
                if (gap_expired) begin
                    st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State, counter, nibble phase and error pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            ph_q  <= 1'b0;
            err_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            ph_q  <= ph_d;
            err_q <= err_d;
        end
    end

    assign frame_busy = (st_q != ST_IDLE);
    assign tx_err     = err_q;

    mtx_crc_nib #(
        .CRC_W    (CRC_W),
        .CRC_POLY (CRC_POLY)
    ) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (crc_clear),
        .fold    (crc_fold),
        .shift   (crc_shift),
        .nib     (core_nib),
        .fcs_nib (fcs_nib)
    );

    mtx_gap_timer #(
        .GAP_CLKS (IPG_NIB)
    ) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (gap_load),
        .run     (st_q == ST_GAP),
        .expired (gap_expired)
    );

    mtx_launch #(
        .NIB_W (4)
    ) u_launch (
        .clk   (clk),
        .rst_n (rst_n),
        .d_nib (core_nib),
        .d_en  (core_en),
        .q_nib (mii_txd),
        .q_en  (mii_tx_en)
    );

endmodule

// File: rtl/mtx_checker.sv
`timescale 1ns/1ps
// mtx_checker: protocol properties of the MII transmit framer, bound
// into every instance of the top module.
// Assumes the default gap of 24 clocks.
module mtx_checker #(
    parameter int IPG_NIB = 24
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic       in_eof,
    input logic [3:0] mii_txd,
    input logic       mii_tx_en,
    input logic       tx_err,
    input logic       core_en,
    input logic [3:0] core_nib,
    input logic       frame_busy
);
    localparam int RW = $clog2(IPG_NIB + 1);

    logic [RW-1:0] low_run;

    // Saturating count of clocks with the enable low at the pins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run <= RW'(IPG_NIB);
        end else if (mii_tx_en) begin
            low_run <= '0;
        end else if (low_run != RW'(IPG_NIB)) begin
            low_run <= low_run + 1'b1;
        end
    end

    AST_LAUNCH_EN: assert property (@(posedge clk) disable iff (!rst_n)
        mii_tx_en == core_en);                                             // R2
    AST_LAUNCH_TXD: assert property (@(posedge clk) disable iff (!rst_n)
        mii_txd == core_nib);                                              // R2
    AST_IDLE_TXD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !mii_tx_en |-> (mii_txd == 4'h0));                                 // R10
    AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mii_tx_en) |-> (low_run >= RW'(IPG_NIB)));                   // R5
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_err |=> !tx_err);                                               // R7
    AST_FCS_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_eof && frame_busy) |=> core_en);       // R4
    AST_TAKE_WITH_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && frame_busy) |-> core_en);                             // R6

endmodule

bind mii_tx_framer mtx_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_eof     (in_eof),
    .mii_txd    (mii_txd),
    .mii_tx_en  (mii_tx_en),
    .tx_err     (tx_err),
    .core_en    (core_en),
    .core_nib   (core_nib),
    .frame_busy (frame_busy)
);

// File: tb/tb_mii_tx_framer.sv
`timescale 1ns/1ps
// tb_mii_tx_framer: scoreboard bench. The driver pushes the expected wire
// nibbles of each frame into a queue; the monitor pops them at the pins.
module tb_mii_tx_framer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_sof = 1'b0;
    logic       in_eof = 1'b0;
    wire        in_ready;
    wire  [3:0] mii_txd;
    wire        mii_tx_en;
    wire        tx_err;

    always #10 clk = ~clk;

    mii_tx_framer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_sof    (in_sof),
        .in_eof    (in_eof),
        .in_ready  (in_ready),
        .mii_txd   (mii_txd),
        .mii_tx_en (mii_tx_en),
        .tx_err    (tx_err)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    int    err_seen = 0;
    int    exp_q[$];
    string tag_q[$];
    logic [7:0] frame_buf [0:127];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic logic [31:0] ref_crc(input int nbytes);
        logic [31:0] c;
        c = 32'hFFFFFFFF;
        for (int i = 0; i < nbytes; i++) begin
            for (int b = 0; b < 8; b++) begin
                if (c[0] ^ frame_buf[i][b]) c = (c >> 1) ^ 32'hEDB88320;
                else                        c = c >> 1;
            end
        end
        return c;
    endfunction

    task automatic fill(input int seed, input int nbytes);
        for (int i = 0; i < nbytes; i++) frame_buf[i] = 8'(i * 37 + seed);
    endtask

    task automatic push_exp(input int v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    // Expected nibbles for a frame; an aborted frame carries no FCS
    task automatic push_frame(input int nbytes, input bit aborted);
        logic [31:0] fcs;
        for (int i = 0; i < 15; i++) push_exp(5, "R3");
        push_exp(13, "R3");
        for (int i = 0; i < nbytes; i++) begin
            push_exp(int'(frame_buf[i][3:0]), "R1");
            push_exp(int'(frame_buf[i][7:4]), "R1");
        end
        if (!aborted) begin
            fcs = ~ref_crc(nbytes);
            for (int i = 0; i < 8; i++) push_exp(int'(fcs[4*i +: 4]), "R4");
            push_exp(-1, "R4");
        end else begin
            push_exp(-1, "R7");
        end
    endtask

    // Offer a frame; call and return at rising edge + 5 ns
    task automatic drive_frame(input int nbytes, input bit abort_after,
                               input bit from_idle);
        int waits;
        push_frame(nbytes, abort_after);
        for (int i = 0; i < nbytes; i++) begin
            in_valid = 1'b1;
            in_data  = frame_buf[i];
            in_sof   = (i == 0);
            in_eof   = (i == nbytes - 1) && !abort_after;
            waits = 0;
            forever begin
                #1;
                if (in_ready) break;
                waits++;
                @(posedge clk); #5;
            end
            if (i == 0 && from_idle)
                check(waits == 18, "R6", "first byte wait from idle", waits, 18);
            else if (i == 0)
                check(waits >= 18, "R6", "first byte wait after gap", waits, 18);
            else
                check(waits == 1, "R6", "wait for later byte", waits, 1);
            @(posedge clk); #5;
        end
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eof   = 1'b0;
    endtask

    task automatic settle();
        while (exp_q.size() != 0) begin
            @(posedge clk); #5;
        end
        repeat (40) @(posedge clk);
        #5;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Monitor: stability around the rising edge, then scoreboard compare
    initial begin
        logic       a_en, prev_en;
        logic [3:0] a_d;
        int         low_run, v;
        string      tg;
        prev_en = 1'b0;
        low_run = 100;
        forever begin
            @(negedge clk); #7;
            a_en = mii_tx_en;
            a_d  = mii_txd;
            @(posedge clk); #3;
            if (rst_n) begin
                check((a_en == mii_tx_en) && (a_d == mii_txd), "R2",
                      "pins moved across rising edge",
                      int'({mii_tx_en, mii_txd}), int'({a_en, a_d}));
            end
            #2;
            if (rst_n) begin
                if (tx_err) err_seen++;
                if (mii_tx_en) begin
                    if (!prev_en)
                        check(low_run >= 24, "R5", "gap before frame", low_run, 24);
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R1", "unexpected nibble", int'(mii_txd), -1);
                    end else begin
                        v  = exp_q.pop_front();
                        tg = tag_q.pop_front();
                        check(v == int'(mii_txd), tg, "nibble", int'(mii_txd), v);
                    end
                    low_run = 0;
                end else begin
                    check(mii_txd == 4'h0, "R10", "txd while idle", int'(mii_txd), 0);
                    if (prev_en) begin
                        if (exp_q.size() == 0) begin
                            check(1'b0, "R1", "frame end not expected", 0, -1);
                        end else begin
                            v  = exp_q.pop_front();
                            tg = tag_q.pop_front();
                            check(v == -1, tg, "frame ended early", 0, v);
                        end
                    end
                    low_run++;
                end
                prev_en = mii_tx_en;
            end
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // Stimulus
    initial begin
        logic [31:0] kc;
        repeat (3) @(posedge clk);
        #5;
        check(mii_tx_en == 1'b0, "R9", "tx_en in reset", int'(mii_tx_en), 0);
        check(mii_txd == 4'h0, "R9", "txd in reset", int'(mii_txd), 0);
        check(in_ready == 1'b0, "R9", "ready in reset", int'(in_ready), 0);
        check(tx_err == 1'b0, "R9", "err in reset", int'(tx_err), 0);

        // Bench CRC model against the well-known check value
        for (int i = 0; i < 9; i++) frame_buf[i] = 8'(8'h31 + i);
        kc = ~ref_crc(9);
        check(kc == 32'hCBF43926, "R4", "crc model check value", int'(kc), 32'hCBF43926);

        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        #5;

        // R8: stray byte in idle is swallowed without transmission
        in_valid = 1'b1; in_data = 8'hAA; in_sof = 1'b0; in_eof = 1'b0;
        #1;
        check(in_ready == 1'b1, "R8", "stray byte ready", int'(in_ready), 1);
        @(posedge clk); #5;
        in_valid = 1'b0;
        repeat (30) @(posedge clk);
        #5;
        check(exp_q.size() == 0, "R8", "no frame after stray byte", exp_q.size(), 0);

        // Long frame from idle
        fill(3, 64);
        drive_frame(64, 1'b0, 1'b1);
        settle();

        // One-byte frame, then a frame offered while the gap runs (R5)
        fill(200, 1);
        drive_frame(1, 1'b0, 1'b1);
        fill(91, 17);
        drive_frame(17, 1'b0, 1'b0);
        settle();

        // R7: underrun after five bytes
        fill(17, 5);
        drive_frame(5, 1'b1, 1'b1);
        settle();
        check(err_seen == 1, "R7", "error pulse count", err_seen, 1);

        // Recovery after abort
        fill(140, 60);
        drive_frame(60, 1'b0, 1'b1);
        settle();
        check(err_seen == 1, "R7", "no error on clean frame", err_seen, 1);
        check(exp_q.size() == 0, "R1", "scoreboard drained", exp_q.size(), 0);

        finish_run();
    end

endmodule